// File: doc/BRIEF.md
# Gated Pulse-Count Frequency Digitizer

This block turns the rate of an incoming pulse train into a digital code. The pulse source is a synchronous voltage-to-frequency stage that runs from the same master clock. Its output rate sits at one tenth of the reference rate for a zero input and at nine tenths for full scale. The digitizer builds a measurement window, the gate, by binary division of its own clock. Any drift or jitter in that clock therefore scales the pulse rate and the window alike, and the result depends only on the ratio between them.

While the gate is open, rising edges of the pulse input are counted after a two-flop synchronizer. When the gate closes, the count is latched and the counter is cleared. The block then removes the ten-percent offset from the latched count and divides by the eighty-percent span. The result is a corrected code saturated to the code range. The block's clock runs at 2^OS_LOG times the reference rate, so that a pulse train near full scale still gives level changes a whole clock apart. The gate length is a power of two of reference periods, picked at run time.

Results leave through a valid/ready stream. A result stays offered until it is taken. If the next gate closes first, the newer result replaces the pending one, because a measurement can never be paused.

Top module: `vfd_digitizer`

## Requirements
- R1: While rst_n is low and in the first clock after it, out_valid, out_count and out_code are all zero.
- R2: With an effective gate exponent L, the gate is open for 2^(L+OS_LOG) clocks and then closed for the same number. The gate that follows reset uses L = LOG_MIN. A result is offered in the clock after the last open cycle: 2^(L+OS_LOG) clocks after reset release for the first gate, and one full open-plus-closed period after the previous result for each later gate.
- R3: Only rising edges of pulse_in are counted, and only while the gate is open. A level change driven before clock edge t is counted at edge t+2. Edges whose count edge falls in the closed phase are ignored.
- R4: The counter is cleared when a gate closes, so each result counts only its own gate.
- R5: With count C and N = 2^L, out_code = floor((10*C - N) * 2^CODE_W / (8*N)).
- R6: When 10*C <= N, out_code is 0.
- R7: When the R5 value exceeds 2^CODE_W - 1, out_code is 2^CODE_W - 1.
- R8: gate_sel is sampled on the last closed-phase clock and sets L for the following gate. Values below LOG_MIN clamp to LOG_MIN, and values above LOG_MAX clamp to LOG_MAX.
- R9: out_valid stays high with unchanged data until a clock edge where out_ready is high. With out_ready held high, out_valid lasts exactly one clock.
- R10: If a gate closes while a result is still pending, the new result replaces it and out_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 2^OS_LOG times the reference rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse train to measure |
| gate_sel | input | SEL_W | Requested gate exponent L |
| out_ready | input | 1 | Consumer can take the result |
| out_valid | output | 1 | A result is offered |
| out_count | output | CNT_W | Raw edge count of the last gate |
| out_code | output | CODE_W | Offset- and span-corrected code |

## Verification
A pulse level change driven on a falling clock edge is counted three rising edges later, at the second rising edge after the one that samples it. The bench therefore places every pulse at least a few clocks inside the open or closed phase, so each one has only one possible outcome. Each result is due at a fixed number of clocks after the previous one: the closed length of the gate that just ended plus the open length chosen through gate_sel. The bench counts falling edges from the last result and samples out_valid and the data exactly there. It also checks that nothing is offered one clock earlier. The one-clock strobe is checked on the first falling edge after a result, and a held result is checked on the same edge while out_ready is low.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic {
    PH_OPEN   = 1'b0,
    PH_CLOSED = 1'b1
  } gate_phase_e;

  localparam int unsigned OFFSET_NUM = 10;
  localparam int unsigned SPAN_SHIFT = 3;
endpackage

// File: rtl/vfd_sync_edge.sv
module vfd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/vfd_gate_timer.sv
module vfd_gate_timer
  import vfd_pkg::*;
#(
  parameter int LOG_MIN = 4,
  parameter int LOG_MAX = 12,
  parameter int OS_LOG  = 1,
  parameter int SEL_W   = 4,
  parameter int PH_W    = LOG_MAX + OS_LOG + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             in_gate,
  output logic             gate_end,
  output logic [SEL_W-1:0] l_act
);
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  half;
  logic [PH_W-1:0]  period_m1;
  logic [SEL_W:0]   shamt;
  logic [SEL_W-1:0] sel_clamped;
  logic             wrap;
  gate_phase_e      phase;

  always_comb begin
    shamt     = {1'b0, l_act} + (SEL_W+1)'(OS_LOG);
    half      = PH_W'(1) << shamt;
    period_m1 = (half << 1) - PH_W'(1);
    phase     = ((ph & half) == '0) ? PH_OPEN : PH_CLOSED;
    in_gate   = (phase == PH_OPEN);
    gate_end  = in_gate && (ph == half - PH_W'(1));
    wrap      = (ph == period_m1);
    if (sel < SEL_W'(LOG_MIN))      sel_clamped = SEL_W'(LOG_MIN);
    else if (sel > SEL_W'(LOG_MAX)) sel_clamped = SEL_W'(LOG_MAX);
    else                            sel_clamped = sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      l_act <= SEL_W'(LOG_MIN);
    end else if (wrap) begin
      ph    <= '0;
      l_act <= sel_clamped;
    end else begin
      ph    <= ph + PH_W'(1);
    end
  end
endmodule

// File: rtl/vfd_scale.sv
module vfd_scale
  import vfd_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int CODE_W = 12,
  parameter int SEL_W  = 4
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SEL_W-1:0]  l_act,
  output logic [CODE_W-1:0] code
);
  localparam int W = CNT_W + CODE_W + 5;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [W-1:0]   ten_c;
  logic [W-1:0]   n_ref;
  logic [W-1:0]   diff;
  logic [W-1:0]   quo;
  logic [SEL_W:0] down;

  always_comb begin
    ten_c = W'(cnt) * W'(OFFSET_NUM);
    n_ref = W'(1) << l_act;
    down  = {1'b0, l_act} + (SEL_W+1)'(SPAN_SHIFT);
    diff  = ten_c - n_ref;
    quo   = (diff << CODE_W) >> down;
    if (ten_c <= n_ref)          code = '0;
    else if (quo > W'(CODE_MAX)) code = CODE_MAX;
    else                         code = quo[CODE_W-1:0];
  end
endmodule

// File: rtl/vfd_digitizer.sv
module vfd_digitizer #(
  parameter int LOG_MIN     = 4,
  parameter int LOG_MAX     = 12,
  parameter int OS_LOG      = 1,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(LOG_MAX + 1),
  parameter int CNT_W       = LOG_MAX + OS_LOG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_in,
  input  logic [SEL_W-1:0]  gate_sel,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CNT_W-1:0]  out_count,
  output logic [CODE_W-1:0] out_code
);
  logic              rise;
  logic              in_gate;
  logic              gate_end;
  logic [SEL_W-1:0]  l_act;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_final;
  logic [CODE_W-1:0] code_next;

  vfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pulse_in),
    .rise (rise)
  );

  vfd_gate_timer #(
    .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .OS_LOG(OS_LOG), .SEL_W(SEL_W)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (gate_sel),
    .in_gate (in_gate),
    .gate_end(gate_end),
    .l_act   (l_act)
  );

  assign cnt_final = cnt + CNT_W'(rise);

  vfd_scale #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_scale (
    .cnt  (cnt_final),
    .l_act(l_act),
    .code (code_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (gate_end) cnt <= '0;
    else if (in_gate)  cnt <= cnt_final;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
      out_code  <= '0;
    end else if (gate_end) begin
      out_valid <= 1'b1;
      out_count <= cnt_final;
      out_code  <= code_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vfd_digitizer_chk.sv
module vfd_digitizer_chk #(
  parameter int LOG_MIN = 4,
  parameter int LOG_MAX = 12,
  parameter int SEL_W   = 4,
  parameter int CNT_W   = 14,
  parameter int CODE_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_ready,
  input logic              out_valid,
  input logic [CNT_W-1:0]  out_count,
  input logic [CODE_W-1:0] out_code,
  input logic              gate_end,
  input logic [SEL_W-1:0]  l_act
);
  AST_END_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> out_valid);  // R2
  AST_OFFER_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(gate_end));  // R2
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);  // R9
  AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !gate_end |=> !out_valid);  // R9
  AST_PENDING_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !gate_end |=> $stable(out_count) && $stable(out_code));  // R10
  AST_EMPTY_GATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_count == '0) |-> (out_code == '0));  // R6
  AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_act >= SEL_W'(LOG_MIN)) && (l_act <= SEL_W'(LOG_MAX)));  // R8
endmodule

bind vfd_digitizer vfd_digitizer_chk #(
  .LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .SEL_W(SEL_W), .CNT_W(CNT_W), .CODE_W(CODE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_ready(out_ready),
  .out_valid(out_valid),
  .out_count(out_count),
  .out_code (out_code),
  .gate_end (gate_end),
  .l_act    (l_act)
);

// File: tb/sim_vfd_digitizer.sv
module sim_vfd_digitizer;
  localparam int LOG_MIN = 4;
  localparam int LOG_MAX = 12;
  localparam int OS_LOG  = 1;
  localparam int CODE_W  = 12;
  localparam int SEL_W   = 4;
  localparam int CNT_W   = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pulse_in = 1'b0;
  logic              out_ready = 1'b1;
  logic [SEL_W-1:0]  gate_sel = '0;
  logic              out_valid;
  logic [CNT_W-1:0]  out_count;
  logic [CODE_W-1:0] out_code;

  int total = 0;
  int bad = 0;
  int hold_h = 0;
  int last_k = 0;

  always #5 clk = ~clk;

  vfd_digitizer u0 (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_sel(gate_sel),
    .out_ready(out_ready), .out_valid(out_valid), .out_count(out_count), .out_code(out_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_code(input int l, input longint k);
    longint n = longint'(1) << l;
    longint v = 10 * k - n;
    longint q;
    if (v <= 0) return 0;
    q = (v << CODE_W) >> (l + 3);
    if (q > (longint'(1) << CODE_W) - 1) q = (longint'(1) << CODE_W) - 1;
    return q;
  endfunction

  function automatic int clamp_l(input int s);
    if (s < LOG_MIN) return LOG_MIN;
    if (s > LOG_MAX) return LOG_MAX;
    return s;
  endfunction

  // Entered on the falling edge where a result is offered.
  task automatic run_frame(input int lsel, input int k, input int lowk, input bit rdy);
    int  l_eff = clamp_l(lsel);
    int  hnew  = 1 << (l_eff + OS_LOG);
    int  span  = hold_h + hnew;
    longint ec = exp_code(l_eff, k);
    gate_sel  = SEL_W'(lsel);
    out_ready = rdy;
    for (int j = 0; j < span; j++) begin
      bit lo_p = (j >= 2) && (j < 2 + 2 * lowk) && (((j - 2) % 2) == 0);
      bit hi_p = (j >= hold_h + 2) && (j < hold_h + 2 + 2 * k) && (((j - hold_h - 2) % 2) == 0);
      pulse_in = lo_p | hi_p;
      @(negedge clk);
      if (j + 1 == 1) begin
        if (rdy) chk(!out_valid, "R9 strobe one clock", longint'(out_valid), 0);
        else begin
          chk(out_valid, "R9 held while not ready", longint'(out_valid), 1);
          chk(out_count == CNT_W'(last_k), "R9 data stable", longint'(out_count), last_k);
        end
      end
      if (rdy && (j + 1 == span - 1))
        chk(!out_valid, "R2 no early result", longint'(out_valid), 0);
    end
    pulse_in = 1'b0;
    chk(out_valid, "R2 result on time", longint'(out_valid), 1);
    chk(out_count == CNT_W'(k), (rdy ? "R3 R4 count" : "R10 newer count replaces"),
        longint'(out_count), k);
    if (ec == 0)
      chk(out_code == '0, "R6 code floor", longint'(out_code), ec);
    else if (ec == (longint'(1) << CODE_W) - 1)
      chk(longint'(out_code) == ec, "R7 code ceiling", longint'(out_code), ec);
    else
      chk(longint'(out_code) == ec, "R5 code", longint'(out_code), ec);
    hold_h = hnew;
    last_k = k;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int waited = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 valid in reset", longint'(out_valid), 0);
    chk(out_count == '0, "R1 count in reset", longint'(out_count), 0);
    chk(out_code == '0, "R1 code in reset", longint'(out_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    waited = 1;
    chk(!out_valid && out_count == '0, "R1 after release", longint'(out_valid), 0);
    while (!out_valid && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited == (1 << (LOG_MIN + OS_LOG)), "R2 first gate length", waited, 1 << (LOG_MIN + OS_LOG));
    chk(out_count == '0, "R6 idle count", longint'(out_count), 0);
    hold_h = 1 << (LOG_MIN + OS_LOG);
    last_k = 0;

    // Smallest gate, every count the window allows, with ignored closed-phase pulses.
    for (int k = 0; k <= 12; k++) run_frame(4, k, k % 4, 1'b1);
    // Middle gate, even steps.
    for (int k = 0; k <= 28; k += 2) run_frame(5, k, 3, 1'b1);
    // Gate large enough to reach the ceiling.
    for (int k = 0; k <= 60; k += 3) run_frame(6, k, 5, 1'b1);
    run_frame(6, 58, 2, 1'b1);
    run_frame(6, 57, 2, 1'b1);
    // Held result overwritten by the next gate.
    run_frame(5, 11, 1, 1'b0);
    run_frame(5, 7, 1, 1'b0);
    run_frame(5, 3, 1, 1'b1);
    // Requests outside the exponent range (R8).
    run_frame(2, 12, 2, 1'b1);
    run_frame(0, 2, 2, 1'b1);
    run_frame(15, 3700, 4, 1'b1);
    run_frame(4, 9, 4, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule